// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This block is the multiply execution unit of a simple integer core. It keeps a 64-bit accumulator split into two 32-bit halves, HI and LO, and carries out a family of 32x32 multiply operations. Each operation is chosen by the function code, which selects signed or unsigned multiply, and by the 5-bit shift-amount field of the instruction. A zero shift field gives the ordinary multiply, which loads HI:LO with the product. A nonzero shift field selects one of the extended forms. These forms can negate the product, add it to HI:LO or subtract it from HI:LO, and they also return one half of the new accumulator for the destination register.

The unit accepts a new operation on any cycle. The result appears two cycles after the start strobe. The accumulator is read and written only in the final stage, so an operation issued directly behind another one sees the HI/LO value that the earlier operation leaves.

Top module: `mac_hilo_unit`

## Requirements
- R1: Reset clears HI and LO to zero, and no done, fault or write-enable pulse occurs before the first start.
- R2: With function code 0x18 (signed) or 0x19 (unsigned) and shift field 0, the 64-bit product is loaded into HI:LO, done pulses and rd_we stays low.
- R3: Function code 0x18 sign-extends both operands to 64 bits before the multiply, and 0x19 zero-extends them.
- R4: The shift field selects the operation with ext_en high. The product itself is selected by 0x09. The negated product (0 minus product, modulo 2^64) is selected by 0x03 or 0x0B. HI:LO plus the product is selected by 0x05 or 0x0D. HI:LO minus the product is selected by 0x07 or 0x0F.
- R5: After every operation that does not fault, LO holds bits 31:0 of the 64-bit result and HI holds bits 63:32.
- R6: Shift-field codes 0x03, 0x05 and 0x07 drive the new LO on rd_data with rd_we high. Codes 0x09, 0x0B, 0x0D and 0x0F drive the new HI instead.
- R7: These cases raise ri_fault together with done: any other nonzero shift-field value, or a function code other than 0x18/0x19. In that case rd_we stays low and HI and LO keep their values.
- R8: With ext_en low, every nonzero shift-field value faults as in R7, and a zero shift field still works as in R2.
- R9: done is a one-cycle pulse that comes exactly two clock edges after the edge that samples start. rd_we and ri_fault are only ever high together with done.
- R10: A start may be given on every cycle. Each operation then uses the HI:LO left by the operation issued just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe for one operation |
| ext_en | input | 1 | Enables the extended (nonzero shift field) forms |
| funct | input | 6 | Function code, 0x18 signed or 0x19 unsigned |
| sa_field | input | 5 | Shift-amount field, selects the operation |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| rd_data | output | 32 | Value for the destination register |
| rd_we | output | 1 | Destination register write enable |
| ri_fault | output | 1 | Reserved-instruction fault |
| done | output | 1 | Operation complete |

## Verification
Two events can fall in the same cycle. One is the final stage of an accumulate updating HI:LO. The other is the final stage of the next operation, one cycle later, reading that same HI:LO, or a new start being taken on the edge where a result retires. To provoke both, the bench issues the whole operand and code sweep and a long random stream back to back with no idle cycles. It keeps its own accumulator model in issue order and compares each retiring result, its write enable, its fault flag and its exact retire cycle against that model.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam logic [5:0] FUNC_MUL_S = 6'h18;
  localparam logic [5:0] FUNC_MUL_U = 6'h19;
  localparam int unsigned SAW = 5;

  typedef enum logic [1:0] {
    K_MUL = 2'b00,
    K_NEG = 2'b01,
    K_ADD = 2'b10,
    K_SUB = 2'b11
  } mkind_e;

  typedef struct packed {
    mkind_e kind;
    logic   wb_en;
    logic   wb_hi;
    logic   sgn;
    logic   flt;
  } mctl_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [5:0]     funct,
  input  logic [SAW-1:0] sa_field,
  input  logic           ext_en,
  output mctl_t          ctl
);

  logic f_ok;
  logic sa_zero;
  logic ext_ok;

  always_comb begin
    f_ok    = (funct == FUNC_MUL_S) || (funct == FUNC_MUL_U);
    sa_zero = (sa_field == '0);
    ext_ok  = ext_en && sa_field[0] && !sa_field[4] && (sa_field[3:1] != 3'b000);

    ctl.sgn   = (funct == FUNC_MUL_S);
    ctl.flt   = !f_ok || (!sa_zero && !ext_ok);
    ctl.wb_en = !sa_zero;
    ctl.wb_hi = sa_field[3];
    if (sa_zero) ctl.kind = K_MUL;
    else         ctl.kind = mkind_e'(sa_field[2:1]);
  end

endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  mctl_t           in_ctl,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  output logic            out_vld,
  output mctl_t           out_ctl,
  output logic [2*DW-1:0] out_prod
);

  localparam int unsigned PW = 2 * DW;

  logic          v1_q;
  mctl_t         ctl1_q;
  logic [DW-1:0] a1_q, b1_q;
  logic          v2_q;
  mctl_t         ctl2_q;
  logic [PW-1:0] prod2_q;

  logic [PW-1:0] ext_a, ext_b, prod_d;

  always_comb begin
    ext_a  = {{DW{ctl1_q.sgn & a1_q[DW-1]}}, a1_q};
    ext_b  = {{DW{ctl1_q.sgn & b1_q[DW-1]}}, b1_q};
    prod_d = ext_a * ext_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      ctl1_q <= '0;
      a1_q   <= '0;
      b1_q   <= '0;
    end else begin
      v1_q <= in_vld;
      if (in_vld) begin
        ctl1_q <= in_ctl;
        a1_q   <= in_a;
        b1_q   <= in_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q    <= 1'b0;
      ctl2_q  <= '0;
      prod2_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        ctl2_q  <= ctl1_q;
        prod2_q <= prod_d;
      end
    end
  end

  assign out_vld  = v2_q;
  assign out_ctl  = ctl2_q;
  assign out_prod = prod2_q;

endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  mctl_t           in_ctl,
  input  logic [2*DW-1:0] in_prod,
  output logic [DW-1:0]   hi,
  output logic [DW-1:0]   lo,
  output logic [DW-1:0]   rd_data,
  output logic            rd_we,
  output logic            fault,
  output logic            done
);

  localparam int unsigned PW = 2 * DW;

  logic [DW-1:0] hi_q, lo_q;
  logic [PW-1:0] acc, res;
  logic          upd_en;

  always_comb begin
    acc = {hi_q, lo_q};
    unique case (in_ctl.kind)
      K_MUL:   res = in_prod;
      K_NEG:   res = '0 - in_prod;
      K_ADD:   res = acc + in_prod;
      K_SUB:   res = acc - in_prod;
      default: res = in_prod;
    endcase
    upd_en  = in_vld && !in_ctl.flt;
    done    = in_vld;
    fault   = in_vld && in_ctl.flt;
    rd_we   = upd_en && in_ctl.wb_en;
    rd_data = in_ctl.wb_hi ? res[PW-1:DW] : res[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (upd_en) begin
      hi_q <= res[PW-1:DW];
      lo_q <= res[DW-1:0];
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  AST_HI_RETURN_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we && in_ctl.wb_hi) |=> (hi_q == $past(rd_data))); // R6
  AST_LO_RETURN_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we && !in_ctl.wb_hi) |=> (lo_q == $past(rd_data))); // R6

endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ext_en,
  input  logic [5:0]    funct,
  input  logic [4:0]    sa_field,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] rd_data,
  output logic          rd_we,
  output logic          ri_fault,
  output logic          done
);

  localparam int unsigned PW = 2 * DW;

  mctl_t         dec_ctl;
  logic          m_vld;
  mctl_t         m_ctl;
  logic [PW-1:0] m_prod;
  logic [DW-1:0] hi_w, lo_w;

  mac_decode u_dec (
    .funct    (funct),
    .sa_field (sa_field),
    .ext_en   (ext_en),
    .ctl      (dec_ctl)
  );

  mac_mult #(.DW(DW)) u_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (start),
    .in_ctl   (dec_ctl),
    .in_a     (opnd_a),
    .in_b     (opnd_b),
    .out_vld  (m_vld),
    .out_ctl  (m_ctl),
    .out_prod (m_prod)
  );

  mac_acc #(.DW(DW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (m_vld),
    .in_ctl  (m_ctl),
    .in_prod (m_prod),
    .hi      (hi_w),
    .lo      (lo_w),
    .rd_data (rd_data),
    .rd_we   (rd_we),
    .fault   (ri_fault),
    .done    (done)
  );

  AST_WE_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (done && !ri_fault)); // R9
  AST_FAULT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ri_fault |-> done); // R9
  AST_FAULT_KEEPS_HILO: assert property (@(posedge clk) disable iff (!rst_n)
    ri_fault |=> ($stable(hi_w) && $stable(lo_w))); // R7
  AST_DONE_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2)); // R9
  AST_PLAIN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sa_field == 5'd0) |-> ##2 !rd_we); // R2

endmodule

// File: tb/test_mac_hilo_unit.sv
`timescale 1ns/1ps
module test_mac_hilo_unit;

  localparam int QN = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ext_en = 1'b0;
  logic [5:0]  funct = 6'h18;
  logic [4:0]  sa_field = 5'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] rd_data;
  logic        rd_we, ri_fault, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int icount = 0;
  int rcount = 0;

  logic [31:0] m_hi = '0, m_lo = '0;
  logic [31:0] q_rd  [0:QN-1];
  logic        q_we  [0:QN-1];
  logic        q_flt [0:QN-1];
  int          q_cyc [0:QN-1];
  string       q_tag [0:QN-1];

  mac_hilo_unit i_mac_hilo_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_en(ext_en),
    .funct(funct), .sa_field(sa_field), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .rd_data(rd_data), .rd_we(rd_we), .ri_fault(ri_fault), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model, in issue order. Codes per R2..R8.
  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [5:0] f, input logic [4:0] s,
                       input logic en, input string tag);
    logic [63:0] ea, eb, p, acc, r;
    logic flt, sgn, legal;
    sgn   = (f == 6'h18);
    legal = (s == 5'h03) || (s == 5'h05) || (s == 5'h07) || (s == 5'h09) ||
            (s == 5'h0B) || (s == 5'h0D) || (s == 5'h0F);
    flt = !((f == 6'h18) || (f == 6'h19)) || ((s != 0) && (!en || !legal));
    ea  = sgn ? {{32{a[31]}}, a} : {32'd0, a};
    eb  = sgn ? {{32{b[31]}}, b} : {32'd0, b};
    p   = ea * eb;
    acc = {m_hi, m_lo};
    case (s)
      5'h03, 5'h0B: r = 64'd0 - p;
      5'h05, 5'h0D: r = acc + p;
      5'h07, 5'h0F: r = acc - p;
      default:      r = p;
    endcase
    q_flt[icount] = flt;
    q_we[icount]  = !flt && (s != 0);
    q_rd[icount]  = (s < 5'h09) ? r[31:0] : r[63:32];
    q_tag[icount] = tag;
    if (!flt) begin
      m_hi = r[63:32];
      m_lo = r[31:0];
    end
    @(negedge clk);
    start = 1'b1; opnd_a = a; opnd_b = b; funct = f; sa_field = s; ext_en = en;
    q_cyc[icount] = cyc;
    icount++;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Retire monitor: R9 latency, R6 return value, R7/R8 fault, R2 no write.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (rcount >= icount) begin
        chk(1'b0, "R9", "unexpected done", 64'(rcount), 64'(icount));
      end else begin
        chk(cyc == q_cyc[rcount] + 2, "R9", "done cycle", 64'(cyc), 64'(q_cyc[rcount] + 2));
        chk(ri_fault == q_flt[rcount], q_tag[rcount], "fault", 64'(ri_fault), 64'(q_flt[rcount]));
        chk(rd_we == q_we[rcount], q_tag[rcount], "rd_we", 64'(rd_we), 64'(q_we[rcount]));
        if (q_we[rcount])
          chk(rd_data == q_rd[rcount], q_tag[rcount], "rd_data", 64'(rd_data), 64'(q_rd[rcount]));
        rcount++;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [31:0] vals [0:5];
  logic [4:0]  codes [0:7];

  initial begin
    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h1234_5678;
    codes[0] = 5'h00; codes[1] = 5'h03; codes[2] = 5'h05; codes[3] = 5'h07;
    codes[4] = 5'h09; codes[5] = 5'h0B; codes[6] = 5'h0D; codes[7] = 5'h0F;

    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(!done && !rd_we && !ri_fault, "R1", "outputs in reset",
        64'({done, rd_we, ri_fault}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !rd_we && !ri_fault, "R1", "outputs after reset",
        64'({done, rd_we, ri_fault}), 64'd0);
    // R1: HI and LO read back zero through zero-product accumulates
    issue(0, 0, 6'h18, 5'h05, 1'b1, "R1");
    issue(0, 0, 6'h18, 5'h0D, 1'b1, "R1");

    // R3/R4/R5/R6/R10: back-to-back sweep over codes, signedness, operands
    foreach (codes[k]) begin
      for (int fs = 0; fs < 2; fs++) begin
        for (int i = 0; i < 6; i++) begin
          for (int j = 0; j < 6; j++) begin
            issue(vals[i], vals[j], fs ? 6'h19 : 6'h18, codes[k], 1'b1,
                  (codes[k] == 0) ? "R2" : (fs ? "R3" : "R4"));
            // R2/R5: expose HI and LO after a plain multiply
            if (codes[k] == 0) begin
              issue(0, 0, 6'h18, 5'h05, 1'b1, "R5");
              issue(0, 0, 6'h18, 5'h0D, 1'b1, "R5");
            end
          end
        end
      end
    end
    idle(4);

    // R7: every shift-field value, both codes, plus a foreign function code
    for (int s = 0; s < 32; s++) begin
      issue(32'hDEAD_BEEF, 32'h0000_0003, 6'h19, 5'(s), 1'b1, "R7");
      issue(32'h8765_4321, 32'hFFFF_FFF0, 6'h18, 5'(s), 1'b1, "R7");
      issue(32'h5, 32'h7, 6'h1A, 5'(s), 1'b1, "R7");
      issue(0, 0, 6'h18, 5'h05, 1'b1, "R7");
      issue(0, 0, 6'h18, 5'h0D, 1'b1, "R7");
    end
    idle(2);

    // R8: extended forms disabled
    for (int s = 0; s < 32; s++) begin
      issue(32'h0001_0001, 32'hFFFF_0003, 6'h18, 5'(s), 1'b0, "R8");
      issue(0, 0, 6'h18, 5'h05, 1'b1, "R8");
      issue(0, 0, 6'h18, 5'h0D, 1'b1, "R8");
    end
    idle(3);

    // R10: random back-to-back stream
    for (int n = 0; n < 400; n++) begin
      logic [4:0] s;
      logic [5:0] f;
      int pick;
      pick = $urandom_range(0, 9);
      s = (pick < 8) ? codes[pick] : 5'($urandom);
      f = ($urandom_range(0, 15) == 0) ? 6'h1B : (($urandom_range(0, 1) != 0) ? 6'h19 : 6'h18);
      issue($urandom, $urandom, f, s, ($urandom_range(0, 7) != 0), "R10");
    end
    // force a nonzero accumulator before the second reset
    issue(32'hFFFF_FFFF, 32'h2, 6'h19, 5'h00, 1'b1, "R2");
    idle(5);
    chk(rcount == icount, "R9", "all retired", 64'(rcount), 64'(icount));

    // R1: reset after activity clears HI and LO
    rst_n = 1'b0;
    m_hi = '0;
    m_lo = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    issue(0, 0, 6'h19, 5'h0D, 1'b1, "R1");
    issue(0, 0, 6'h19, 5'h05, 1'b1, "R1");
    idle(5);
    chk(rcount == icount, "R9", "all retired at end", 64'(rcount), 64'(icount));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule